// File: doc/BRIEF.md
# One-Shot Primitive Override Injector

This block sits between a link-layer state machine and the transmit multiplexer. Each clock cycle the state machine presents the primitive it would normally send, together with its current state code. Normally the block passes that primitive through unchanged.

For debug, software can force a different primitive into one slot. It programs a target state code and a 32-bit replacement dword, then raises an enable bit. The rising edge of that bit arms the block. The next time the link state equals the target, the block sends the replacement dword instead of the normal primitive, for exactly one cycle. It also pulses a fired flag that a status register can capture.

After that the block stays idle. Software must drop the enable and raise it again before another substitution can happen. Dropping the enable while the block is armed, before the target state appears, cancels the pending override.

A typical use is to replace a single hold primitive with a sync primitive. In that case the target state is the one that sends hold (code 16) and the replacement is 0xB5B5957C.

Top module: `prim_override_inject`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `prim_o` equals `prim_i` and `fired_o` is 0.
- R2: In every cycle without a substitution, `prim_o` equals `prim_i`.
- R3: Only a 0-to-1 transition of `cfg_en_i`, seen at a clock edge, arms the block. An enable that stays high after a substitution does not arm it again.
- R4: A substitution happens only in a cycle where the block is armed, `cfg_en_i` is 1 and `link_state_i` equals `cfg_state_i` (all 5 bits). In that cycle `prim_o` equals `cfg_prim_i`.
- R5: An arm produces at most one substitution. Later matching cycles pass `prim_i` through while the enable stays high.
- R6: Clearing `cfg_en_i` for at least one cycle and then setting it again re-arms the block for one more substitution.
- R7: If `cfg_en_i` is 0 in any cycle while the block is armed, the pending override is cancelled and no substitution follows until a new arm.
- R8: `fired_o` is 1 exactly in the cycles where a substitution happens, so it is never high in two consecutive cycles.
- R9: Arming takes effect from the cycle after the one in which the enable first reads 1. A match in that first cycle does not substitute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| link_state_i | input | 5 | Current state code of the link state machine |
| prim_i | input | 32 | Primitive the state machine would send this cycle |
| cfg_state_i | input | 5 | Programmed target state code |
| cfg_prim_i | input | 32 | Programmed replacement primitive |
| cfg_en_i | input | 1 | Override enable; its rising edge arms the block |
| prim_o | output | 32 | Primitive sent to the transmit multiplexer |
| fired_o | output | 1 | One-cycle pulse marking the substitution |

## Verification
On every cycle, the assertions check the following properties. A fire only happens on a state match with the enable high, and it carries the replacement dword. Every other cycle passes the normal primitive through. The fired flag and the enable's edge pulse are never high on consecutive cycles. An enable that stays high never yields a second fire.

Some behaviours only the bench's scenarios can show. The first of these is that the substitution lands at the first matching state after an arm, for each of the 32 target codes. The bench also shows the ignored match in the arming cycle, the cancellation of a pending arm, and re-arming through a low-then-high enable.

// File: rtl/po_pkg.sv
package po_pkg;
  typedef enum logic [0:0] {
    ARM_IDLE = 1'b0,
    ARM_WAIT = 1'b1
  } arm_state_e;
endpackage

// File: rtl/po_rst_sync.sv
module po_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/po_edge_det.sv
module po_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;
  logic lvl_d;

  always_comb lvl_d = lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_d;
  end

  assign rise_o = lvl_i & ~lvl_q;

  // R3: an edge pulse can never repeat on the next cycle
  p_rise_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/po_arm_ctrl.sv
module po_arm_ctrl
  import po_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rise_i,
  input  logic match_i,
  output logic fire_o
);
  arm_state_e state_q, state_d;
  logic       state_upd;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARM_IDLE: if (rise_i) state_d = ARM_WAIT;
      ARM_WAIT: if (!en_i || match_i) state_d = ARM_IDLE;
      default:  state_d = ARM_IDLE;
    endcase
    state_upd = (state_d != state_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= ARM_IDLE;
    else if (state_upd) state_q <= state_d;
  end

  assign fire_o = (state_q == ARM_WAIT) & en_i & match_i;

  // R5: with the enable held high, a fire is not followed by another
  p_no_refire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && en_i) |=> !fire_o);
  // R7: a low enable never lets a substitution through
  p_cancel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !fire_o);
  // R9: arming is entered only from a detected edge
  p_arm_from_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ARM_WAIT) && $past(state_q == ARM_IDLE) |-> $past(rise_i));
endmodule

// File: rtl/po_prim_mux.sv
module po_prim_mux #(
  parameter int PRIM_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [PRIM_W-1:0] norm_i,
  input  logic [PRIM_W-1:0] repl_i,
  output logic [PRIM_W-1:0] prim_o
);
  always_comb prim_o = sel_i ? repl_i : norm_i;

  // R2: without a select the normal primitive passes
  p_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> prim_o == norm_i);
endmodule

// File: rtl/prim_override_inject.sv
module prim_override_inject #(
  parameter int STATE_W = 5,
  parameter int PRIM_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STATE_W-1:0] link_state_i,
  input  logic [PRIM_W-1:0]  prim_i,
  input  logic [STATE_W-1:0] cfg_state_i,
  input  logic [PRIM_W-1:0]  cfg_prim_i,
  input  logic               cfg_en_i,
  output logic [PRIM_W-1:0]  prim_o,
  output logic               fired_o
);
  logic rst_sync_n;
  logic en_rise;
  logic state_hit;
  logic fire;

  po_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_sync_n));

  po_edge_det u_edge (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .lvl_i(cfg_en_i), .rise_o(en_rise));

  always_comb state_hit = (link_state_i == cfg_state_i);

  po_arm_ctrl u_arm (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .en_i(cfg_en_i),
    .rise_i(en_rise), .match_i(state_hit), .fire_o(fire));

  po_prim_mux #(.PRIM_W(PRIM_W)) u_mux (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .sel_i(fire),
    .norm_i(prim_i), .repl_i(cfg_prim_i), .prim_o(prim_o));

  assign fired_o = fire;

  // R4: a fire requires a state match and carries the replacement
  p_fire_match_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    fired_o |-> (link_state_i == cfg_state_i) && (prim_o == cfg_prim_i));
  // R8: the fired flag is a single-cycle pulse
  p_fired_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    fired_o |=> !fired_o);
endmodule

// File: tb/test_prim_override_inject.sv
module test_prim_override_inject;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  link_state, cfg_state;
  logic [31:0] prim_in, cfg_prim, prim_out;
  logic        cfg_en, fired;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prim_override_inject i_prim_override_inject (
    .clk_i(clk), .rst_ni(rst_n), .link_state_i(link_state), .prim_i(prim_in),
    .cfg_state_i(cfg_state), .cfg_prim_i(cfg_prim), .cfg_en_i(cfg_en),
    .prim_o(prim_out), .fired_o(fired));

  // drive at the falling edge, check combinational outputs 1 ns later
  task automatic step(input logic en, input logic [4:0] st, input logic exp_fire,
                      input string req);
    logic [31:0] exp_p;
    @(negedge clk);
    cfg_en = en; link_state = st;
    prim_in = {8'h3C, 3'b0, st, 16'hC3A5} ^ {27'd0, st};
    #1;
    exp_p = exp_fire ? cfg_prim : prim_in;
    total++;
    if (prim_out !== exp_p || fired !== exp_fire) begin
      bad++;
      $display("FAIL %s: prim=%h fired=%b expected prim=%h fired=%b",
               req, prim_out, fired, exp_p, exp_fire);
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_en = 0; cfg_state = 5'd16; cfg_prim = 32'hB5B5957C;
    link_state = 0; prim_in = 0;
    // R1: reset state with a matching state present
    step(1'b0, 5'd16, 1'b0, "R1");
    step(1'b0, 5'd16, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 5'd16, 1'b0, "R1");
    step(1'b0, 5'd16, 1'b0, "R1");
    // R2: passthrough while not armed, all states
    for (int s = 0; s < 32; s++) step(1'b0, 5'(s), 1'b0, "R2");

    // sweep every target state
    for (int t = 0; t < 32; t++) begin
      cfg_state = 5'(t);
      cfg_prim  = 32'hB5B5957C ^ (32'(t) << 8);
      step(1'b0, 5'(t+1), 1'b0, "R2");
      step(1'b1, 5'(t), 1'b0, "R9");            // match in arming cycle ignored
      for (int s = 0; s < 32; s++)               // R4: first match fires
        step(1'b1, 5'(s), (s == t), "R4");
      for (int s = 0; s < 32; s++)               // R5/R3: held enable, no refire
        step(1'b1, 5'(s), 1'b0, "R5");
    end

    // R6: clear then set again re-arms
    cfg_state = 5'd16; cfg_prim = 32'hB5B5957C;
    step(1'b0, 5'd3, 1'b0, "R6");
    step(1'b1, 5'd3, 1'b0, "R6");
    step(1'b1, 5'd16, 1'b1, "R6");
    step(1'b1, 5'd16, 1'b0, "R8");
    step(1'b0, 5'd16, 1'b0, "R6");
    step(1'b1, 5'd2, 1'b0, "R6");
    step(1'b1, 5'd16, 1'b1, "R6");

    // R7: cancel before target
    step(1'b0, 5'd1, 1'b0, "R7");
    step(1'b1, 5'd1, 1'b0, "R7");
    step(1'b1, 5'd2, 1'b0, "R7");
    step(1'b0, 5'd16, 1'b0, "R7");
    step(1'b1, 5'd16, 1'b0, "R7");   // new rising edge, arming cycle
    step(1'b1, 5'd16, 1'b1, "R7");   // fires only after the new arm

    // R3: enable high for a long stretch never rearms
    for (int k = 0; k < 40; k++) step(1'b1, 5'd16, 1'b0, "R3");

    // R8: back-to-back matches give a single pulse
    step(1'b0, 5'd16, 1'b0, "R8");
    step(1'b1, 5'd16, 1'b0, "R8");
    step(1'b1, 5'd16, 1'b1, "R8");
    step(1'b1, 5'd16, 1'b0, "R8");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule